// File: doc/BRIEF.md
# Serial NOR Flash Target Model

This block is a synthesizable stand-in for a small serial NOR flash part. It serves as the far end of a serial-flash master inside a simulation or an emulation build. The model runs on a fast system clock. It oversamples the chip-select, serial-clock and data-in lines, and it drives a data-out bit together with an output enable, so a pad or the testbench can tri-state the line whenever the model is not talking. Its storage is an internal byte array that comes out of reset fully erased (all ones).

The model understands five opcodes: array read, page program, set and clear of the write-enable latch, and status read. It applies the acceptance rules that catch faulty masters:

- A frame that starts with an opcode it does not know is ignored for its whole length, and the line stays released.
- A write-class frame counts only when chip select rises exactly after a whole number of bytes.
- While a program is being applied, array reads and new programs are dropped, and status reads keep working.

The serial clock may idle low or high.

Top module: `flash_emu`

## Requirements
- R1: After reset the output enable is low, the status byte reads 0x00 and every array byte reads 0xFF.
- R2: Input bits are taken MSB first on rising serial-clock edges, and output bits change on falling edges. Transfers behave the same whether the clock idles low (mode 0) or high (mode 3).
- R3: Opcode 0x03 followed by a 24-bit MSB-first address returns array bytes from that address upward. The address increments without limit and wraps from the last array byte to byte 0. Address bits above the array size are ignored.
- R4: Opcode 0x05 returns the status byte for as long as the clock runs. Bit 0 is the write-in-progress flag, bit 1 is the write-enable latch, and the other bits are 0. It works while a program is in progress.
- R5: Opcode 0x06 sets the write-enable latch and opcode 0x04 clears it. Either one takes effect only when chip select rises after exactly 8 bits.
- R6: An unknown opcode leaves the output enable low until chip select rises, changes no state, and the next frame is decoded normally.
- R7: Opcode 0x02 with a 24-bit address and data bytes programs each target byte to old AND data. The column wraps inside its 256-byte page. Without the write-enable latch set, the frame is ignored.
- R8: A program frame is applied only if chip select rises on a data byte boundary. Otherwise nothing is written and the latch is kept.
- R9: An applied program sets write-in-progress at once and holds it for PAGE_BYTES + BUSY_CYCLES system clocks. It then clears write-in-progress and the write-enable latch together.
- R10: While write-in-progress is set, reads leave the output enable low and programs are dropped without disturbing the one in progress.
- R11: A read-class frame may end after any output bit, and the next frame is decoded normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the master |
| spi_mosi | input | 1 | Serial data into the model |
| spi_miso | output | 1 | Serial data out of the model |
| spi_miso_oe | output | 1 | High while the model drives spi_miso |

## Verification
The end of a program can fall in the same system cycle as the first falling clock edge of a status byte, which is the edge where that byte is latched for shifting. The bench starts a program and then polls the status register back to back until the busy flag drops, so one poll lands on the completion point. Each returned byte must be 0x03 or 0x00, never a mix such as 0x01 or 0x02. A later read must show the programmed data, and the write-enable latch must be cleared in the same byte that shows the busy flag clear.

// File: rtl/flash_emu_pkg.sv
package flash_emu_pkg;

    localparam logic [7:0] OP_READ = 8'h03;
    localparam logic [7:0] OP_PROG = 8'h02;
    localparam logic [7:0] OP_WREN = 8'h06;
    localparam logic [7:0] OP_WRDI = 8'h04;
    localparam logic [7:0] OP_RDSR = 8'h05;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD,
        PH_ADDR,
        PH_WCMD,
        PH_PDATA,
        PH_DOUT,
        PH_STBY
    } phase_e;

    typedef enum logic [2:0] {
        C_NONE,
        C_READ,
        C_PROG,
        C_WREN,
        C_WRDI,
        C_RDSR
    } cmd_e;

    typedef struct packed {
        logic [5:0] rsvd;
        logic       wel;
        logic       wip;
    } status_t;

    function automatic cmd_e decode_op(input logic [7:0] op);
        case (op)
            OP_READ: return C_READ;
            OP_PROG: return C_PROG;
            OP_WREN: return C_WREN;
            OP_WRDI: return C_WRDI;
            OP_RDSR: return C_RDSR;
            default: return C_NONE;
        endcase
    endfunction

endpackage

// File: rtl/flash_emu_sync.sv
module flash_emu_sync (
    input  logic clk,
    input  logic rst,
    input  logic cs_n_i,
    input  logic sck_i,
    input  logic mosi_i,
    output logic cs_n_o,
    output logic mosi_o,
    output logic sck_rise_o,
    output logic sck_fall_o,
    output logic cs_rise_o,
    output logic cs_fall_o
);
    // bit 2: chip select, bit 1: serial clock, bit 0: data in
    logic [2:0] st1, st2;
    logic       cs_prev, sck_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            st1      <= 3'b100;
            st2      <= 3'b100;
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            st1      <= {cs_n_i, sck_i, mosi_i};
            st2      <= st1;
            cs_prev  <= st2[2];
            sck_prev <= st2[1];
        end
    end

    assign cs_n_o     = st2[2];
    assign mosi_o     = st2[0];
    assign sck_rise_o = st2[1] & ~sck_prev;
    assign sck_fall_o = ~st2[1] & sck_prev;
    assign cs_rise_o  = st2[2] & ~cs_prev;
    assign cs_fall_o  = ~st2[2] & cs_prev;

endmodule

// File: rtl/flash_emu_mem.sv
module flash_emu_mem #(
    parameter int DEPTH = 1024,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [7:0]    wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [7:0]    rdata_o
);
    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) cells[i] <= 8'hFF;
        end else if (we_i) begin
            // programming can only pull bits low
            cells[waddr_i] <= cells[waddr_i] & wdata_i;
        end
    end

    assign rdata_o = cells[raddr_i];

endmodule

// File: rtl/flash_emu_prog.sv
module flash_emu_prog #(
    parameter int PAGE_BYTES  = 256,
    parameter int BUSY_CYCLES = 200,
    parameter int MEM_AW      = 10
) (
    input  logic                                clk,
    input  logic                                rst,
    input  logic                                clr_i,
    input  logic [MEM_AW-$clog2(PAGE_BYTES)-1:0] page_i,
    input  logic                                wr_i,
    input  logic [$clog2(PAGE_BYTES)-1:0]        col_i,
    input  logic [7:0]                          data_i,
    input  logic                                commit_i,
    output logic                                busy_o,
    output logic                                done_o,
    output logic                                mem_we_o,
    output logic [MEM_AW-1:0]                   mem_addr_o,
    output logic [7:0]                          mem_data_o
);
    localparam int PAGE_AW = $clog2(PAGE_BYTES);
    localparam int PW      = MEM_AW - PAGE_AW;
    localparam int TOTAL   = PAGE_BYTES + BUSY_CYCLES;
    localparam int CW      = $clog2(TOTAL + 1);

    logic [7:0]            pbuf [PAGE_BYTES];
    logic [PAGE_BYTES-1:0] pmask;
    logic [PW-1:0]         page_q;
    logic [CW-1:0]         cnt;
    logic                  busy_q;
    logic [PAGE_AW-1:0]    walk_col;
    logic                  walking;

    always_ff @(posedge clk) begin
        if (wr_i) pbuf[col_i] <= data_i;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pmask  <= '0;
            page_q <= '0;
            cnt    <= '0;
            busy_q <= 1'b0;
        end else begin
            if (clr_i) begin
                pmask  <= '0;
                page_q <= page_i;
            end else if (wr_i) begin
                pmask[col_i] <= 1'b1;
            end
            if (commit_i) begin
                busy_q <= 1'b1;
                cnt    <= '0;
            end else if (busy_q) begin
                if (cnt == CW'(TOTAL - 1)) busy_q <= 1'b0;
                else                       cnt    <= cnt + 1'b1;
            end
        end
    end

    assign walk_col   = cnt[PAGE_AW-1:0];
    assign walking    = busy_q && (cnt < CW'(PAGE_BYTES));
    assign mem_we_o   = walking && pmask[walk_col];
    assign mem_addr_o = {page_q, walk_col};
    assign mem_data_o = pbuf[walk_col];
    assign busy_o     = busy_q;
    assign done_o     = busy_q && (cnt == CW'(TOTAL - 1));

    // R9
    busy_on_commit_chk: assert property (@(posedge clk) disable iff (rst)
        commit_i |=> busy_o);

    // R9
    busy_holds_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_o && !done_o && !commit_i) |=> busy_o);

    // R10
    no_load_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_i || clr_i) |-> !busy_o);

endmodule

// File: rtl/flash_emu.sv
module flash_emu #(
    parameter int MEM_BYTES   = 1024,
    parameter int PAGE_BYTES  = 256,
    parameter int BUSY_CYCLES = 200,
    parameter int ADDR_W      = 24
) (
    input  logic clk,
    input  logic rst,
    input  logic spi_cs_n,
    input  logic spi_sck,
    input  logic spi_mosi,
    output logic spi_miso,
    output logic spi_miso_oe
);
    import flash_emu_pkg::*;

    localparam int MEM_AW     = $clog2(MEM_BYTES);
    localparam int PAGE_AW    = $clog2(PAGE_BYTES);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int ABW        = $clog2(ADDR_BYTES + 1);

    logic cs_s, mosi_s, sck_rise, sck_fall, cs_rise, cs_fall;

    flash_emu_sync u_sync (
        .clk        (clk),
        .rst        (rst),
        .cs_n_i     (spi_cs_n),
        .sck_i      (spi_sck),
        .mosi_i     (spi_mosi),
        .cs_n_o     (cs_s),
        .mosi_o     (mosi_s),
        .sck_rise_o (sck_rise),
        .sck_fall_o (sck_fall),
        .cs_rise_o  (cs_rise),
        .cs_fall_o  (cs_fall)
    );

    phase_e             phase;
    cmd_e               cmd;
    logic [6:0]         sr;
    logic [2:0]         bcnt, ocnt;
    logic [ABW-1:0]     acnt;
    logic [MEM_AW-1:0]  addr_sr, rd_ptr;
    logic [7:0]         osr;
    logic [PAGE_AW-1:0] col;
    logic               wel;

    logic [7:0]        next_byte, mem_rdata, out_byte;
    logic [MEM_AW-1:0] new_addr;
    logic              byte_done, addr_last, in_rise;
    logic              pb_we, pb_clr, commit, busy, prog_done;
    logic              mem_we;
    logic [MEM_AW-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    status_t           st;

    assign in_rise   = sck_rise && !cs_s;
    assign next_byte = {sr, mosi_s};
    assign new_addr  = {addr_sr[MEM_AW-2:0], mosi_s};
    assign byte_done = (bcnt == 3'd7);
    assign addr_last = (acnt == ABW'(ADDR_BYTES - 1));

    always_comb begin
        st      = '0;
        st.wel  = wel;
        st.wip  = busy;
        out_byte = (cmd == C_RDSR) ? 8'(st) : mem_rdata;
    end

    assign pb_we  = in_rise && phase == PH_PDATA && byte_done;
    assign pb_clr = in_rise && phase == PH_ADDR && byte_done && addr_last
                    && cmd == C_PROG && !busy && wel;
    assign commit = cs_rise && phase == PH_PDATA && bcnt == 3'd0;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase       <= PH_IDLE;
            cmd         <= C_NONE;
            sr          <= '0;
            bcnt        <= '0;
            ocnt        <= '0;
            acnt        <= '0;
            addr_sr     <= '0;
            rd_ptr      <= '0;
            osr         <= '0;
            col         <= '0;
            wel         <= 1'b0;
            spi_miso    <= 1'b0;
            spi_miso_oe <= 1'b0;
        end else begin
            if (prog_done) wel <= 1'b0;
            if (cs_fall) begin
                phase <= PH_CMD;
                cmd   <= C_NONE;
                bcnt  <= '0;
                ocnt  <= '0;
                acnt  <= '0;
            end else if (cs_rise) begin
                phase       <= PH_IDLE;
                spi_miso_oe <= 1'b0;
                if (phase == PH_WCMD) wel <= (cmd == C_WREN);
            end else if (in_rise) begin
                sr   <= next_byte[6:0];
                bcnt <= bcnt + 1'b1;
                case (phase)
                    PH_CMD: if (byte_done) begin
                        cmd <= decode_op(next_byte);
                        case (decode_op(next_byte))
                            C_READ, C_PROG: phase <= PH_ADDR;
                            C_WREN, C_WRDI: phase <= PH_WCMD;
                            C_RDSR:         phase <= PH_DOUT;
                            default:        phase <= PH_STBY;
                        endcase
                    end
                    PH_ADDR: begin
                        addr_sr <= new_addr;
                        if (byte_done) begin
                            acnt <= acnt + 1'b1;
                            if (addr_last) begin
                                if (busy) begin
                                    phase <= PH_STBY;
                                end else if (cmd == C_READ) begin
                                    phase  <= PH_DOUT;
                                    rd_ptr <= new_addr;
                                end else if (!wel) begin
                                    phase <= PH_STBY;
                                end else begin
                                    phase <= PH_PDATA;
                                    col   <= new_addr[PAGE_AW-1:0];
                                end
                            end
                        end
                    end
                    PH_WCMD:  phase <= PH_STBY;
                    PH_PDATA: if (byte_done) col <= col + 1'b1;
                    default: ;
                endcase
            end else if (sck_fall && !cs_s && phase == PH_DOUT) begin
                spi_miso_oe <= 1'b1;
                ocnt        <= ocnt + 1'b1;
                if (ocnt == 3'd0) begin
                    spi_miso <= out_byte[7];
                    osr      <= {out_byte[6:0], 1'b0};
                    if (cmd == C_READ) rd_ptr <= rd_ptr + 1'b1;
                end else begin
                    spi_miso <= osr[7];
                    osr      <= {osr[6:0], 1'b0};
                end
            end
        end
    end

    flash_emu_prog #(
        .PAGE_BYTES  (PAGE_BYTES),
        .BUSY_CYCLES (BUSY_CYCLES),
        .MEM_AW      (MEM_AW)
    ) u_prog (
        .clk        (clk),
        .rst        (rst),
        .clr_i      (pb_clr),
        .page_i     (new_addr[MEM_AW-1:PAGE_AW]),
        .wr_i       (pb_we),
        .col_i      (col),
        .data_i     (next_byte),
        .commit_i   (commit),
        .busy_o     (busy),
        .done_o     (prog_done),
        .mem_we_o   (mem_we),
        .mem_addr_o (mem_waddr),
        .mem_data_o (mem_wdata)
    );

    flash_emu_mem #(
        .DEPTH (MEM_BYTES),
        .AW    (MEM_AW)
    ) u_mem (
        .clk     (clk),
        .rst     (rst),
        .we_i    (mem_we),
        .waddr_i (mem_waddr),
        .wdata_i (mem_wdata),
        .raddr_i (rd_ptr),
        .rdata_o (mem_rdata)
    );

    // R6
    standby_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_STBY) |-> !spi_miso_oe);

    // R11
    release_on_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        cs_s |=> !spi_miso_oe);

    // R7
    commit_needs_latch_chk: assert property (@(posedge clk) disable iff (rst)
        commit |-> wel);

    // R10
    no_read_start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && phase != PH_DOUT) |=> !(phase == PH_DOUT && cmd == C_READ));

endmodule

// File: tb/flash_emu_bench.sv
module flash_emu_bench;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;
    localparam int BUSY       = 4000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sck = 1'b0;
    logic mosi = 1'b0;
    logic miso, oe;

    always #(CLK_PERIOD / 2) clk = ~clk;

    flash_emu #(.BUSY_CYCLES(BUSY)) u_flash_emu (
        .clk         (clk),
        .rst         (rst),
        .spi_cs_n    (cs_n),
        .spi_sck     (sck),
        .spi_mosi    (mosi),
        .spi_miso    (miso),
        .spi_miso_oe (oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit m3 = 1'b0;
    bit oe_seen, oe_all;
    logic [7:0] rbuf [4];
    logic [7:0] pdat [4];

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_begin();
        @(negedge clk);
        sck = m3;
        idle(4);
        cs_n = 1'b0;
        idle(HALF);
    endtask

    task automatic frame_end();
        if (!m3) begin
            sck = 1'b0;
            idle(HALF);
        end
        cs_n = 1'b1;
        idle(2 * HALF);
    endtask

    task automatic xfer(input logic [7:0] tx, input int nbits, output logic [7:0] rx);
        rx = 8'h00;
        for (int i = 0; i < nbits; i++) begin
            sck  = 1'b0;
            mosi = tx[7-i];
            idle(HALF);
            rx[7-i] = miso;
            oe_seen = oe_seen | oe;
            oe_all  = oe_all & oe;
            sck = 1'b1;
            idle(HALF);
        end
    endtask

    task automatic send_addr(input logic [23:0] a);
        logic [7:0] d;
        xfer(a[23:16], 8, d);
        xfer(a[15:8], 8, d);
        xfer(a[7:0], 8, d);
    endtask

    task automatic status(output logic [7:0] s);
        logic [7:0] d;
        frame_begin();
        xfer(8'h05, 8, d);
        xfer(8'h00, 8, s);
        frame_end();
    endtask

    task automatic cmd1(input logic [7:0] op, input int nbits);
        logic [7:0] d;
        frame_begin();
        xfer(op, (nbits > 8) ? 8 : nbits, d);
        if (nbits > 8) xfer(8'h00, nbits - 8, d);
        frame_end();
    endtask

    task automatic read_n(input logic [23:0] a, input int n);
        logic [7:0] d;
        frame_begin();
        xfer(8'h03, 8, d);
        send_addr(a);
        oe_seen = 1'b0;
        oe_all  = 1'b1;
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, 8, d);
            rbuf[k] = d;
        end
        frame_end();
    endtask

    task automatic prog(input logic [23:0] a, input int n, input int extra);
        logic [7:0] d;
        frame_begin();
        xfer(8'h02, 8, d);
        send_addr(a);
        for (int k = 0; k < n; k++) xfer(pdat[k], 8, d);
        if (extra > 0) xfer(8'hFF, extra, d);
        frame_end();
    endtask

    task automatic wait_ready(output int polls);
        logic [7:0] s;
        polls = 0;
        do begin
            status(s);
            polls++;
            check("R9 status byte is 03 or 00 around completion",
                  32'((s == 8'h03) || (s == 8'h00)), 32'd1);
        end while (s[0] && polls < 60);
        check("R9 status after completion", 32'(s), 32'h00);
    endtask

    task automatic t_reset();
        logic [7:0] s;
        check("R1 output enable after reset", 32'(oe), 32'd0);
        status(s);
        check("R1 status after reset", 32'(s), 32'h00);
        read_n(24'h000123, 1);
        check("R1 erased array byte", 32'(rbuf[0]), 32'hFF);
        check("R1 read drives line", 32'(oe_all), 32'd1);
    endtask

    task automatic t_latch();
        logic [7:0] s;
        cmd1(8'h06, 8);
        status(s);
        check("R5 set latch", 32'(s), 32'h02);
        cmd1(8'h04, 7);
        status(s);
        check("R5 short clear frame ignored", 32'(s), 32'h02);
        cmd1(8'h04, 8);
        status(s);
        check("R5 clear latch", 32'(s), 32'h00);
        cmd1(8'h06, 9);
        status(s);
        check("R5 long set frame ignored", 32'(s), 32'h00);
        cmd1(8'h06, 7);
        status(s);
        check("R5 short set frame ignored", 32'(s), 32'h00);
    endtask

    task automatic t_unknown();
        logic [7:0] s, d;
        cmd1(8'h06, 8);
        frame_begin();
        xfer(8'h9F, 8, d);
        oe_seen = 1'b0;
        xfer(8'h00, 8, d);
        xfer(8'h00, 8, d);
        frame_end();
        check("R6 line released after unknown opcode", 32'(oe_seen), 32'd0);
        status(s);
        check("R6 latch kept and next frame decoded", 32'(s), 32'h02);
        cmd1(8'h04, 8);
    endtask

    task automatic t_program();
        logic [7:0] s;
        int polls;
        cmd1(8'h06, 8);
        pdat[0] = 8'hA5;
        pdat[1] = 8'h3C;
        prog(24'h000010, 2, 0);
        status(s);
        check("R9 busy and latch right after program", 32'(s), 32'h03);
        wait_ready(polls);
        check("R9 busy lasted several polls", 32'(polls > 3), 32'd1);
        read_n(24'h000010, 3);
        check("R7 first programmed byte", 32'(rbuf[0]), 32'hA5);
        check("R7 second programmed byte", 32'(rbuf[1]), 32'h3C);
        check("R3 next byte untouched", 32'(rbuf[2]), 32'hFF);
        cmd1(8'h06, 8);
        pdat[0] = 8'hF0;
        prog(24'h000010, 1, 0);
        wait_ready(polls);
        read_n(24'h000010, 1);
        check("R7 program ANDs with old value", 32'(rbuf[0]), 32'hA0);
        pdat[0] = 8'h00;
        prog(24'h000011, 1, 0);
        status(s);
        check("R7 program without latch not started", 32'(s), 32'h00);
        read_n(24'h000011, 1);
        check("R7 program without latch ignored", 32'(rbuf[0]), 32'h3C);
    endtask

    task automatic t_partial();
        logic [7:0] s;
        cmd1(8'h06, 8);
        pdat[0] = 8'h00;
        prog(24'h000020, 1, 3);
        status(s);
        check("R8 partial program discarded, latch kept", 32'(s), 32'h02);
        read_n(24'h000020, 1);
        check("R8 partial program wrote nothing", 32'(rbuf[0]), 32'hFF);
        cmd1(8'h04, 8);
    endtask

    task automatic t_page_wrap();
        int polls;
        cmd1(8'h06, 8);
        pdat[0] = 8'h11;
        pdat[1] = 8'h22;
        pdat[2] = 8'h33;
        pdat[3] = 8'h44;
        prog(24'h0001FE, 4, 0);
        wait_ready(polls);
        read_n(24'h0001FE, 2);
        check("R7 bytes at page end", {16'h0, rbuf[0], rbuf[1]}, 32'h1122);
        read_n(24'h000100, 2);
        check("R7 column wrapped to page start", {16'h0, rbuf[0], rbuf[1]}, 32'h3344);
        read_n(24'h000200, 1);
        check("R7 next page untouched", 32'(rbuf[0]), 32'hFF);
    endtask

    task automatic t_busy();
        logic [7:0] s;
        int polls;
        cmd1(8'h06, 8);
        pdat[0] = 8'h5A;
        prog(24'h000040, 1, 0);
        status(s);
        check("R4 status usable while busy", 32'(s), 32'h03);
        read_n(24'h000040, 1);
        check("R10 read while busy leaves line released", 32'(oe_seen), 32'd0);
        pdat[0] = 8'h00;
        prog(24'h000041, 1, 0);
        status(s);
        check("R10 still busy after dropped program", 32'(s), 32'h03);
        wait_ready(polls);
        read_n(24'h000040, 2);
        check("R10 ongoing program completed", 32'(rbuf[0]), 32'h5A);
        check("R10 program during busy dropped", 32'(rbuf[1]), 32'hFF);
    endtask

    task automatic t_mode3();
        logic [7:0] s;
        m3 = 1'b1;
        read_n(24'h000010, 2);
        check("R2 mode 3 read byte 0", 32'(rbuf[0]), 32'hA0);
        check("R2 mode 3 read byte 1", 32'(rbuf[1]), 32'h3C);
        cmd1(8'h06, 8);
        status(s);
        check("R2 mode 3 latch set", 32'(s), 32'h02);
        cmd1(8'h04, 8);
        status(s);
        check("R2 mode 3 latch cleared", 32'(s), 32'h00);
        m3 = 1'b0;
    endtask

    task automatic t_early_end();
        logic [7:0] s, d;
        frame_begin();
        xfer(8'h03, 8, d);
        send_addr(24'h000010);
        xfer(8'h00, 3, d);
        frame_end();
        check("R11 first three data bits", 32'(d[7:5]), 32'h5);
        status(s);
        check("R11 frame after early end decoded", 32'(s), 32'h00);
        read_n(24'h000010, 1);
        check("R11 full read after early end", 32'(rbuf[0]), 32'hA0);
    endtask

    task automatic t_read_wrap();
        int polls;
        cmd1(8'h06, 8);
        pdat[0] = 8'h77;
        prog(24'h000000, 1, 0);
        wait_ready(polls);
        read_n(24'h0003FF, 2);
        check("R3 last array byte", 32'(rbuf[0]), 32'hFF);
        check("R3 read wraps to byte 0", 32'(rbuf[1]), 32'h77);
        read_n(24'h000400, 1);
        check("R3 upper address bits ignored", 32'(rbuf[0]), 32'h77);
    endtask

    initial begin
        idle(5);
        rst = 1'b0;
        idle(5);
        t_reset();
        t_latch();
        t_unknown();
        t_program();
        t_partial();
        t_page_wrap();
        t_busy();
        t_mode3();
        t_early_end();
        t_read_wrap();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all-requirements actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule